// File: doc/BRIEF.md
# Serial LED Frame Shifter

This block streams a 30-bit vector of LED on/off states, without end, over a three-wire serial link made of a clock, a data line and a latch strobe. The link feeds either an LED driver that locks onto a leading start bit or a chain of 8-bit serial-in, parallel-out shift registers that need a strobe to show the shifted value. Every frame lasts 36 serial clocks. The 30 payload bits sit between a one-bit header slot and zero padding: two zero bits lead the payload and three zero bits follow it.

The serial clock comes from dividing the system clock. Data changes on the falling edge of the serial clock, so the receiver can sample it on the rising edge. The LED vector and the format select are captured together at the start of each frame. A change to either input part-way through a frame therefore shows up in the next frame.

A small state machine controls the link. Its states are `S_LOAD`, `S_LOW` and `S_HIGH`:
- `S_LOAD` lasts one cycle after reset. It captures the inputs and presents header bit 1, then moves to `S_LOW`.
- The `S_LOW` to `S_HIGH` transition happens on a divider tick and raises the serial clock.
- The `S_HIGH` to `S_LOW` transition happens on a divider tick. It lowers the serial clock and either advances to the next bit or wraps the frame.

Top module: `led_frame_shifter`

## Requirements
- R1: A frame is exactly 36 serial clock cycles long. After bit 36 the bit counter returns to bit 1 with no gap, so consecutive frame starts are 36 rising edges apart.
- R2: Frame bit 1 carries the format marker. It is logic 1 when `fmt_sel` = 0 (start-bit format) and logic 0 when `fmt_sel` = 1 (latched shift-register format).
- R3: Frame bits 2, 3, 34, 35 and 36 are always logic 0.
- R4: Frame bits 4 to 33 carry `led_vec[0]` to `led_vec[29]` in ascending order, so LED n sits at frame bit n+3. A 1 lights the LED.
- R5: `sdata_o` changes only in the system cycle in which `sclk_o` falls, or once while the clock is low right after reset. It is stable while `sclk_o` is high.
- R6: `sclk_o` has a period of 2·`HALF_DIV` system clocks, with `HALF_DIV` cycles low and `HALF_DIV` cycles high.
- R7: In format 1, `slatch_o` goes high on the falling serial clock edge that ends bit 36. It stays high for one serial period, during bit 1 of the next frame. In format 0, `slatch_o` stays low.
- R8: `led_vec` and `fmt_sel` are captured only at a frame start. Changes inside a frame do not alter that frame.
- R9: A synchronous reset drives `sclk_o`, `sdata_o` and `slatch_o` low and resets the counter to bit 1. The first frame after reset is complete and correctly aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_sel | input | 1 | Frame format: 0 = start-bit, 1 = latched shift-register |
| led_vec | input | 30 | LED states, bit 0 = LED 1, active high |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data, launched on the falling edge |
| slatch_o | output | 1 | Latch strobe, used in format 1 only |

## Verification
The assertions assume that `led_vec` and `fmt_sel` are synchronous to `clk`. They also assume that `HALF_DIV` is at least 1, so a divider tick can never fall in the `S_LOAD` cycle. The bench changes its inputs only between clock edges. It first drives a deliberately wrong value around bit 10 and then the intended next value around bit 18, so the input is always stable when the frame wraps. The bench rebuilds every frame from the rising serial clock edges and predicts its contents from the value it wrote before that frame began. It also applies one reset in the middle of a frame.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
    typedef enum logic [1:0] {
        S_LOAD = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2
    } lfs_state_e;
endpackage

// File: rtl/lfs_clk_div.sv
module lfs_clk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic clr,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr || cnt == LAST) cnt <= '0;
        else                    cnt <= cnt + CW'(1);
    end

    assign tick = !clr && (cnt == LAST);
endmodule

// File: rtl/lfs_bit_sel.sv
module lfs_bit_sel #(
    parameter int LED_W    = 30,
    parameter int LEAD_PAD = 2,
    parameter int IDX_W    = 6
) (
    input  logic             fmt,
    input  logic [LED_W-1:0] vec,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    localparam int PAY_FIRST = 2 + LEAD_PAD;
    localparam logic [IDX_W-1:0] HDR_IDX = IDX_W'(1);

    always_comb begin
        bit_o = 1'b0;
        // Header slot: start bit only in format 0
        if (idx == HDR_IDX) bit_o = ~fmt;
        for (int i = 0; i < LED_W; i++) begin
            if (idx == IDX_W'(PAY_FIRST + i)) bit_o = vec[i];
        end
    end
endmodule

// File: rtl/lfs_seq.sv
module lfs_seq
    import lfs_pkg::*;
#(
    parameter int LED_W     = 30,
    parameter int FRAME_LEN = 36,
    parameter int IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fmt_sel,
    input  logic [LED_W-1:0] led_vec,
    input  logic             tick,
    input  logic             bit_nxt,
    output logic             div_clr,
    output logic             nxt_fmt,
    output logic [LED_W-1:0] nxt_vec,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             sclk_o,
    output logic             sdata_o,
    output logic             slatch_o
);
    localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_LEN);

    lfs_state_e       state, nxt_state;
    logic [IDX_W-1:0] bit_idx;
    logic [LED_W-1:0] hold_q;
    logic             fmt_q;
    logic             advance, wrap, load;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_LOAD;
        else     state <= nxt_state;
    end

    always_comb begin
        nxt_state = state;
        unique case (state)
            S_LOAD: nxt_state = S_LOW;
            S_LOW:  if (tick) nxt_state = S_HIGH;
            S_HIGH: if (tick) nxt_state = S_LOW;
            default: nxt_state = S_LOAD;
        endcase
    end

    always_comb begin
        advance = (state == S_HIGH) && tick;
        wrap    = advance && (bit_idx == IDX_LAST);
        load    = (state == S_LOAD) || wrap;
        div_clr = rst || (state == S_LOAD);
        nxt_idx = bit_idx;
        if (load)         nxt_idx = IDX_FIRST;
        else if (advance) nxt_idx = bit_idx + IDX_W'(1);
        nxt_vec = load ? led_vec : hold_q;
        nxt_fmt = load ? fmt_sel : fmt_q;
    end

    // Output and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_idx  <= IDX_FIRST;
            hold_q   <= '0;
            fmt_q    <= 1'b0;
            sclk_o   <= 1'b0;
            sdata_o  <= 1'b0;
            slatch_o <= 1'b0;
        end else begin
            bit_idx <= nxt_idx;
            hold_q  <= nxt_vec;
            fmt_q   <= nxt_fmt;
            unique case (state)
                S_LOAD: begin
                    sdata_o  <= bit_nxt;
                    slatch_o <= 1'b0;
                end
                S_LOW: begin
                    if (tick) sclk_o <= 1'b1;
                end
                S_HIGH: begin
                    if (tick) begin
                        sclk_o   <= 1'b0;
                        sdata_o  <= bit_nxt;
                        slatch_o <= wrap && fmt_q;
                    end
                end
                default: sclk_o <= 1'b0;
            endcase
        end
    end

    // R6
    clk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (sclk_o != $past(sclk_o)));
    // R6
    clk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(sclk_o));
    // R5
    data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> $stable(sdata_o));
    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_idx >= IDX_FIRST) && (bit_idx <= IDX_LAST));
    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && bit_idx == IDX_LAST) |=> (bit_idx == IDX_FIRST));
    // R7
    latch_slot_chk: assert property (@(posedge clk) disable iff (rst)
        slatch_o |-> (bit_idx == IDX_FIRST));
    // R8
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(hold_q));
endmodule

// File: rtl/led_frame_shifter.sv
module led_frame_shifter #(
    parameter int LED_W    = 30,
    parameter int LEAD_PAD = 2,
    parameter int TAIL_PAD = 3,
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fmt_sel,
    input  logic [LED_W-1:0] led_vec,
    output logic             sclk_o,
    output logic             sdata_o,
    output logic             slatch_o
);
    localparam int FRAME_LEN = 1 + LEAD_PAD + LED_W + TAIL_PAD;
    localparam int IDX_W     = $clog2(FRAME_LEN + 1);

    logic             tick, div_clr, bit_nxt, nxt_fmt;
    logic [LED_W-1:0] nxt_vec;
    logic [IDX_W-1:0] nxt_idx;

    lfs_clk_div #(.HALF_DIV(HALF_DIV)) div_i (
        .clk (clk),
        .clr (div_clr),
        .tick(tick)
    );

    lfs_bit_sel #(.LED_W(LED_W), .LEAD_PAD(LEAD_PAD), .IDX_W(IDX_W)) sel_i (
        .fmt  (nxt_fmt),
        .vec  (nxt_vec),
        .idx  (nxt_idx),
        .bit_o(bit_nxt)
    );

    lfs_seq #(.LED_W(LED_W), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .fmt_sel (fmt_sel),
        .led_vec (led_vec),
        .tick    (tick),
        .bit_nxt (bit_nxt),
        .div_clr (div_clr),
        .nxt_fmt (nxt_fmt),
        .nxt_vec (nxt_vec),
        .nxt_idx (nxt_idx),
        .sclk_o  (sclk_o),
        .sdata_o (sdata_o),
        .slatch_o(slatch_o)
    );
endmodule

// File: tb/led_frame_shifter_tb.sv
module led_frame_shifter_tb_top;
    localparam int LW   = 30;
    localparam int HALF = 2;
    localparam int NFR  = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fmt_sel = 1'b0;
    logic [LW-1:0] led_vec = '0;
    logic          sclk_o, sdata_o, slatch_o;

    led_frame_shifter #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .led_vec(led_vec),
        .sclk_o(sclk_o), .sdata_o(sdata_o), .slatch_o(slatch_o)
    );

    always #2 clk = ~clk;

    int errors = 0, checks = 0;
    int pos = 0, fdone = 0, cyc = 0, rise_n = 0, last_latch = -1;
    int r5_bad = 0, r6_bad = 0;
    logic          prev_sclk = 1'b0, prev_data = 1'b0;
    logic          have_prev = 1'b0, prev_mode = 1'b0, have_rise = 1'b0;
    logic          first_after_rst = 1'b1, latch_prev_frame = 1'b0;
    logic [LW-1:0] cur_vec = '0;
    logic          cur_mode = 1'b0;
    logic [36:1]   rx;

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] pat(input int k);
        if (k < 30)       return LW'(1) << k;
        else if (k == 30) return '0;
        else if (k == 31) return '1;
        else if (k == 32) return 30'h15555555;
        else if (k == 33) return 30'h2AAAAAAA;
        else              return LW'(k * 32'h9E3779B1);
    endfunction

    function automatic logic mode_of(input int k);
        return 1'(k) ^ 1'(k >> 1);
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            pos = 0; have_prev = 0; prev_mode = 0; prev_sclk = 0; prev_data = 0;
            have_rise = 0; cyc = 0; first_after_rst = 1; last_latch = -1;
            latch_prev_frame = 0; cur_vec = led_vec; cur_mode = fmt_sel;
        end else begin
            cyc++;
            if (sdata_o !== prev_data && !(prev_sclk && !sclk_o)
                && !(pos == 0 && !sclk_o && !prev_sclk)) r5_bad++;
            if (sclk_o && !prev_sclk) begin
                if (have_rise && cyc != 2 * HALF) r6_bad++;
                have_rise = 1; cyc = 0; rise_n++;
                pos = (pos == 36) ? 1 : pos + 1;
                rx[pos] = sdata_o;
                chk(slatch_o === ((pos == 1) && have_prev && prev_mode), "R7",
                    "latch at rising edge", slatch_o, (pos == 1) && have_prev && prev_mode);
                if (slatch_o && pos == 1) begin
                    if (last_latch >= 0 && latch_prev_frame)
                        chk(rise_n - last_latch == 36, "R1", "frame start spacing",
                            rise_n - last_latch, 36);
                    last_latch = rise_n;
                end
                if (pos == 36) begin
                    chk(rx[1] === ~cur_mode, "R2", "header bit", rx[1], ~cur_mode);
                    chk({rx[2], rx[3], rx[34], rx[35], rx[36]} === 5'b0, "R3", "pad bits",
                        {rx[2], rx[3], rx[34], rx[35], rx[36]}, 0);
                    chk(rx[33:4] === cur_vec, "R4/R8", "payload", rx[33:4], cur_vec);
                    if (first_after_rst)
                        chk(rx === {3'b0, cur_vec, 2'b0, ~cur_mode}, "R9",
                            "first frame after reset", rx, {3'b0, cur_vec, 2'b0, ~cur_mode});
                    first_after_rst = 0;
                    latch_prev_frame = have_prev && prev_mode;
                    prev_mode = cur_mode; have_prev = 1;
                    cur_vec = led_vec; cur_mode = fmt_sel;
                    fdone++;
                end
            end
            prev_sclk = sclk_o; prev_data = sdata_o;
        end
    end

    initial begin
        led_vec = pat(0); fmt_sel = mode_of(0);
        repeat (5) @(negedge clk);
        chk({sclk_o, sdata_o, slatch_o} === 3'b000, "R9", "outputs in reset",
            {sclk_o, sdata_o, slatch_o}, 0);
        #1 rst = 1'b0;
        for (int k = 0; k < NFR; k++) begin
            wait (fdone == k && pos == 10);
            #1 led_vec = ~pat(k + 1); fmt_sel = ~mode_of(k + 1);
            wait (pos == 18);
            #1 led_vec = pat(k + 1); fmt_sel = mode_of(k + 1);
        end
        wait (fdone == NFR && pos == 20);
        #1 rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({sclk_o, sdata_o, slatch_o} === 3'b000, "R9", "outputs after mid-frame reset",
            {sclk_o, sdata_o, slatch_o}, 0);
        #1 rst = 1'b0;
        wait (fdone == NFR + 2);
        @(negedge clk);
        chk(r5_bad == 0, "R5", "data changes outside falling edge", r5_bad, 0);
        chk(r6_bad == 0, "R6", "serial clock period violations", r6_bad, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule